// File: doc/BRIEF.md
# Speech High-Pass Biquad Preprocessor

This block removes low-frequency content, below a 140 Hz corner at an 8 kHz sample rate, from a stream of signed 16-bit speech samples before they reach an encoder. It is a second-order IIR section in transposed form. Two signed 32-bit state words carry the filter memory from one sample to the next. The fixed-point arithmetic follows a codec's bit-exact recipe, so a software model of the same equations produces identical output.

A sample is accepted when `in_valid_i` and `in_ready_o` are both high. One shared multiplier then evaluates the seven coefficient products in sequence. The first of them builds the output accumulator, which goes through a saturating left shift of up to three steps and is then rounded. The filtered sample appears for one cycle with `out_valid_o`. The block then finishes updating its state and raises `in_ready_o` again. A synchronous clear returns the filter to its zero state.

Top module: `hpf_preproc`

## Requirements
- R1: After reset `in_ready_o` is 1, `out_valid_o` is 0, `out_data_o` is 0, and both state words are zero, so a first input of 0 produces an output of 0.
- R2: `in_ready_o` falls in the cycle after a sample is accepted and stays low until that sample's state update is complete. While it is low, `in_valid_i` and `in_data_i` are ignored and do not change any output.
- R3: Each accepted sample produces exactly one `out_valid_o` pulse, one cycle long.
- R4: The output accumulator is y = u1 + 2·x·b0 in a 40-bit signed accumulator. All products are doubled. The Q12 constants are b0 = b2 = 1899, b1 = -3798, a1 = 7807 and a2 = -3733, and these constants already include the halving of the input.
- R5: Bit 0 of the accumulator is forced to 0 at three points: after y is accumulated, after the a1·y product is formed, and after the a2·y product is formed.
- R6: y is shifted left by up to three one-bit steps. Before each step, a value above 0x3FFFFFFF becomes 0x7FFFFFFF and a value below -0x40000000 becomes -0x80000000. Either saturation ends the shift at once.
- R7: Each feedback product a·y is formed from the shifted 32-bit y. The unsigned low 16 bits times the coefficient, doubled, are shifted right arithmetically by 16. The signed high 16 bits times the coefficient, doubled, are then added.
- R8: New state is u1 = mask(a1·y) + u2_old + 2·x·b1 and u2 = mask(a2·y) + 2·x·b2. Each result is truncated to 32 bits two's complement.
- R9: `out_data_o` is the upper 16 bits of (y + 0x8000), arithmetic. If that value exceeds 32767, the output is clamped to 32767.
- R10: `clear_i` zeroes both state words and aborts any sample in progress, which then produces no output. A sample offered in a cycle where `clear_i` is high is discarded.
- R11: State words persist across any number of samples, so each output depends on the full input history since the last clear or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous state clear and abort |
| in_valid_i | input | 1 | Input sample offered |
| in_ready_o | output | 1 | Block can accept a sample |
| in_data_i | input | 16 | Signed input sample |
| out_valid_o | output | 1 | One-cycle strobe for a filtered sample |
| out_data_o | output | 16 | Signed filtered sample |

## Verification
The hardest condition to reach from the ports is saturation in the shift stage. With this filter's gain, the halved output nearly never exceeds full scale, so ordinary speech-like input never exercises the saturation and output clamp paths. To get there, the bench first derives the filter's impulse response from its reference model. It then feeds a full-scale sequence whose signs follow that response in reverse, which drives one output toward the worst-case peak. Long full-scale steps and tiny-amplitude alternations are also applied: the steps exercise large state swings, and the alternations make the least-significant-bit masking visible in the rounded output.

// File: rtl/hpf_pkg.sv
package hpf_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_Y,
    ST_SHIFT,
    ST_A1L,
    ST_A1H,
    ST_B1,
    ST_A2L,
    ST_A2H,
    ST_B2
  } hpf_state_e;

endpackage

// File: rtl/hpf_mul.sv
// Shared signed multiplier; product sign-extended to accumulator width and doubled.
module hpf_mul #(
  parameter int MW = 17,
  parameter int CW = 16,
  parameter int AW = 40
) (
  input  logic signed [MW-1:0] op_a_i,
  input  logic signed [CW-1:0] coef_i,
  output logic signed [AW-1:0] prod_o
);

  localparam int PW = MW + CW;

  logic signed [PW-1:0] raw;
  logic signed [AW-1:0] ext;

  assign raw    = op_a_i * coef_i;
  assign ext    = {{(AW-PW){raw[PW-1]}}, raw};
  assign prod_o = ext <<< 1;

endmodule

// File: rtl/hpf_sat_step.sv
// One step of the saturating left shift.
module hpf_sat_step #(
  parameter int AW = 40,
  parameter int SW = 32
) (
  input  logic signed [AW-1:0] val_i,
  output logic signed [AW-1:0] nxt_o,
  output logic                 sat_o
);

  localparam logic signed [AW-1:0] POS_LIM = AW'((longint'(1) <<< (SW-2)) - 1);
  localparam logic signed [AW-1:0] NEG_LIM = -POS_LIM - 1;
  localparam logic signed [AW-1:0] POS_SAT = AW'((longint'(1) <<< (SW-1)) - 1);
  localparam logic signed [AW-1:0] NEG_SAT = -POS_SAT - 1;

  always_comb begin
    sat_o = 1'b1;
    if (val_i > POS_LIM) begin
      nxt_o = POS_SAT;
    end else if (val_i < NEG_LIM) begin
      nxt_o = NEG_SAT;
    end else begin
      nxt_o = val_i <<< 1;
      sat_o = 1'b0;
    end
  end

endmodule

// File: rtl/hpf_ctrl.sv
// Sequencer for one sample: y, shift, two feedback products per state word.
module hpf_ctrl
  import hpf_pkg::*;
#(
  parameter int STEPS = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       start_i,
  input  logic       shift_sat_i,
  output hpf_state_e state_o,
  output logic       idle_o,
  output logic       shift_done_o
);

  localparam int SCW = $clog2(STEPS + 1);

  hpf_state_e       state_q, state_d;
  logic [SCW-1:0]   step_q;

  assign state_o      = state_q;
  assign idle_o       = (state_q == ST_IDLE);
  assign shift_done_o = (state_q == ST_SHIFT) &&
                        (shift_sat_i || (step_q == SCW'(STEPS - 1)));

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_Y;
      ST_Y:     state_d = ST_SHIFT;
      ST_SHIFT: if (shift_done_o) state_d = ST_A1L;
      ST_A1L:   state_d = ST_A1H;
      ST_A1H:   state_d = ST_B1;
      ST_B1:    state_d = ST_A2L;
      ST_A2L:   state_d = ST_A2H;
      ST_A2H:   state_d = ST_B2;
      ST_B2:    state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    if (clear_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_Y) begin
        step_q <= '0;
      end else if (state_q == ST_SHIFT && !shift_done_o) begin
        step_q <= step_q + SCW'(1);
      end
    end
  end

  // R6
  step_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q < SCW'(STEPS));

  // R2
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_A1L && !clear_i) |=> (state_q == ST_A1H));

endmodule

// File: rtl/hpf_preproc.sv
module hpf_preproc
  import hpf_pkg::*;
#(
  parameter int XW    = 16,
  parameter int SW    = 32,
  parameter int AW    = 40,
  parameter int CW    = 16,
  parameter int STEPS = 3,
  parameter logic signed [CW-1:0] COEF_B0 = 16'sd1899,
  parameter logic signed [CW-1:0] COEF_B1 = -16'sd3798,
  parameter logic signed [CW-1:0] COEF_B2 = 16'sd1899,
  parameter logic signed [CW-1:0] COEF_A1 = 16'sd7807,
  parameter logic signed [CW-1:0] COEF_A2 = -16'sd3733
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [XW-1:0] in_data_i,
  output logic          out_valid_o,
  output logic [XW-1:0] out_data_o
);

  localparam int HW = SW / 2;
  localparam int MW = HW + 1;
  localparam logic [AW-1:0]        CLR0    = {{(AW-1){1'b1}}, 1'b0};
  localparam logic signed [AW-1:0] RND_ADD = AW'(longint'(1) <<< (HW-1));
  localparam logic signed [AW-1:0] OUT_MAX = AW'((longint'(1) <<< (XW-1)) - 1);
  localparam logic signed [AW-1:0] POS_SAT = AW'((longint'(1) <<< (SW-1)) - 1);
  localparam logic signed [AW-1:0] NEG_SAT = -POS_SAT - 1;

  hpf_state_e state;
  logic       idle, start, shift_done, shift_sat;

  logic signed [XW-1:0] x_q;
  logic signed [SW-1:0] u1_q, u2_q;
  logic signed [AW-1:0] y_q, acc_q;
  logic [XW-1:0]        out_q;
  logic                 out_vld_q;

  logic signed [MW-1:0] mul_a;
  logic signed [CW-1:0] mul_c;
  logic signed [AW-1:0] prod, step_nxt, u1_ext, u2_ext, rnd_sum, rnd_hi;
  logic [XW-1:0]        rnd_out;
  logic signed [MW-1:0] x_ext, ylo_ext, yhi_ext;

  assign start       = in_valid_i && idle && !clear_i;
  assign in_ready_o  = idle;
  assign out_valid_o = out_vld_q;
  assign out_data_o  = out_q;

  assign u1_ext  = {{(AW-SW){u1_q[SW-1]}}, u1_q};
  assign u2_ext  = {{(AW-SW){u2_q[SW-1]}}, u2_q};
  assign x_ext   = {{(MW-XW){x_q[XW-1]}}, x_q};
  assign ylo_ext = {1'b0, y_q[HW-1:0]};
  assign yhi_ext = {y_q[SW-1], y_q[SW-1:HW]};

  hpf_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_i),
    .start_i     (start),
    .shift_sat_i (shift_sat),
    .state_o     (state),
    .idle_o      (idle),
    .shift_done_o(shift_done)
  );

  always_comb begin
    mul_a = x_ext;
    mul_c = COEF_B0;
    case (state)
      ST_A1L:  begin mul_a = ylo_ext; mul_c = COEF_A1; end
      ST_A1H:  begin mul_a = yhi_ext; mul_c = COEF_A1; end
      ST_B1:   begin mul_a = x_ext;   mul_c = COEF_B1; end
      ST_A2L:  begin mul_a = ylo_ext; mul_c = COEF_A2; end
      ST_A2H:  begin mul_a = yhi_ext; mul_c = COEF_A2; end
      ST_B2:   begin mul_a = x_ext;   mul_c = COEF_B2; end
      default: begin mul_a = x_ext;   mul_c = COEF_B0; end
    endcase
  end

  hpf_mul #(.MW(MW), .CW(CW), .AW(AW)) u_mul (
    .op_a_i(mul_a),
    .coef_i(mul_c),
    .prod_o(prod)
  );

  hpf_sat_step #(.AW(AW), .SW(SW)) u_sat (
    .val_i(y_q),
    .nxt_o(step_nxt),
    .sat_o(shift_sat)
  );

  // round half up on the final shifted value, clamp at positive full scale
  assign rnd_sum = step_nxt + RND_ADD;
  assign rnd_hi  = rnd_sum >>> HW;
  assign rnd_out = (rnd_hi > OUT_MAX) ? XW'(OUT_MAX) : XW'(rnd_hi);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q       <= '0;
      u1_q      <= '0;
      u2_q      <= '0;
      y_q       <= '0;
      acc_q     <= '0;
      out_q     <= '0;
      out_vld_q <= 1'b0;
    end else begin
      out_vld_q <= 1'b0;
      if (clear_i) begin
        u1_q <= '0;
        u2_q <= '0;
      end else begin
        case (state)
          ST_IDLE:  if (start) x_q <= in_data_i;
          ST_Y:     y_q <= (u1_ext + prod) & CLR0;
          ST_SHIFT: begin
            y_q <= step_nxt;
            if (shift_done) begin
              out_q     <= rnd_out;
              out_vld_q <= 1'b1;
            end
          end
          ST_A1L:   acc_q <= prod >>> HW;
          ST_A1H:   acc_q <= ((acc_q + prod) & CLR0) + u2_ext;
          ST_B1:    u1_q  <= SW'(acc_q + prod);
          ST_A2L:   acc_q <= prod >>> HW;
          ST_A2H:   acc_q <= (acc_q + prod) & CLR0;
          ST_B2:    u2_q  <= SW'(acc_q + prod);
          default:  ;
        endcase
      end
    end
  end

  // R3
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  // R2
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && !clear_i) |=> !in_ready_o);

  // R6
  shift_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (y_q <= POS_SAT && y_q >= NEG_SAT));

  // R10
  clear_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (in_ready_o && !out_valid_o));

  // R3
  valid_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

endmodule

// File: tb/sim_hpf_preproc.sv
module sim_hpf_preproc;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clear_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [15:0] in_data_i = '0;
  logic        out_valid_o;
  logic [15:0] out_data_o;

  always #5 clk_i = ~clk_i;

  hpf_preproc u0 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear_i),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .in_data_i  (in_data_i),
    .out_valid_o(out_valid_o),
    .out_data_o (out_data_o)
  );

  localparam longint K_B0 = 1899;
  localparam longint K_B1 = -3798;
  localparam longint K_B2 = 1899;
  localparam longint K_A1 = 7807;
  localparam longint K_A2 = -3733;

  localparam int STIM_N = 24;
  localparam int STIM [STIM_N] = '{
    0, 1000, -1000, 4000, 12000, -20000, 32767, 32767, -32768, -32768,
    5, -5, 300, 299, -7777, 16384, -16384, 25000, 25000, 25000,
    -1, 1, 0, 0
  };
  localparam int HLEN = 200;

  int     n_chk = 0;
  int     n_fail = 0;
  int     sat_events = 0;
  bit     done = 0;
  longint m_u1 = 0;
  longint m_u2 = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint wrap32(input longint v);
    logic [63:0] b;
    b = v;
    return longint'($signed(b[31:0]));
  endfunction

  task automatic model_step(input longint x, output longint y16, output longint y32);
    longint acc, ylo, yhi, t, nu1;
    bit     stop;
    acc  = (m_u1 + 2 * x * K_B0) & ~64'sd1;
    stop = 0;
    for (int k = 0; k < 3; k++) begin
      if (!stop) begin
        if (acc > 64'sh3FFFFFFF) begin
          acc = 64'sh7FFFFFFF; stop = 1; sat_events++;
        end else if (acc < -64'sh40000000) begin
          acc = -64'sh80000000; stop = 1; sat_events++;
        end else begin
          acc = acc * 2;
        end
      end
    end
    y32 = acc;
    ylo = acc & 64'sh0000FFFF;
    yhi = acc >>> 16;
    t   = (2 * ylo * K_A1) >>> 16;
    t   = (t + 2 * yhi * K_A1) & ~64'sd1;
    nu1 = wrap32(t + m_u2 + 2 * x * K_B1);
    t   = (2 * ylo * K_A2) >>> 16;
    t   = (t + 2 * yhi * K_A2) & ~64'sd1;
    m_u2 = wrap32(t + 2 * x * K_B2);
    m_u1 = nu1;
    t = (acc + 32768) >>> 16;
    if (t > 32767) t = 32767;
    y16 = t;
  endtask

  task automatic push(input longint x, output int got, output int lat);
    @(negedge clk_i);
    while (!in_ready_o) @(negedge clk_i);
    in_valid_i = 1'b1;
    in_data_i  = 16'(x);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    lat = 1;
    while (!out_valid_o && lat < 40) begin
      @(negedge clk_i);
      lat++;
    end
    got = $signed(out_data_o);
  endtask

  task automatic run_sample(input longint x, input string req);
    longint e16, e32;
    int     got, lat;
    model_step(x, e16, e32);
    push(x, got, lat);
    chk(lat < 40 && longint'(got) == e16, req, got, e16);
  endtask

  task automatic quiet_window(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (out_valid_o) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    longint hresp [HLEN];
    longint e16, e32, su1, su2;
    int     got, lat, seen, ssat;

    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(in_ready_o == 1'b1, "R1 ready in reset", in_ready_o, 1);
    chk(out_valid_o == 1'b0, "R1 valid in reset", out_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(out_data_o == 16'h0, "R1 data after reset", out_data_o, 0);
    chk(in_ready_o == 1'b1, "R1 ready after reset", in_ready_o, 1);
    run_sample(0, "R1 zero state");

    // R4 R7 R8 R11 vector table walk
    for (int i = 0; i < STIM_N; i++) begin
      run_sample(STIM[i], "R4 R7 R8 R11 table");
    end

    // R3 single pulse and latency
    model_step(12345, e16, e32);
    push(12345, got, lat);
    chk(longint'(got) == e16, "R3 data", got, e16);
    chk(lat <= 6, "R3 latency", lat, 6);
    @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R3 pulse width", out_valid_o, 0);

    // R2 input held valid while busy is ignored
    model_step(-9000, e16, e32);
    @(negedge clk_i);
    while (!in_ready_o) @(negedge clk_i);
    in_valid_i = 1'b1;
    in_data_i  = 16'(-9000);
    @(negedge clk_i);
    in_data_i = 16'h3039;
    seen = 0;
    got  = 0;
    while (!in_ready_o) begin
      if (out_valid_o) begin seen++; got = $signed(out_data_o); end
      @(negedge clk_i);
    end
    in_valid_i = 1'b0;
    chk(seen == 1, "R2 one output while busy", seen, 1);
    chk(longint'(got) == e16, "R2 busy data", got, e16);
    run_sample(7000, "R2 next sample unaffected");

    // R10 clear while idle
    @(negedge clk_i);
    clear_i = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0;
    m_u1 = 0; m_u2 = 0;
    run_sample(20000, "R10 after idle clear");

    // R10 clear aborts a sample in progress
    @(negedge clk_i);
    while (!in_ready_o) @(negedge clk_i);
    in_valid_i = 1'b1;
    in_data_i  = 16'd30000;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    clear_i    = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0;
    chk(in_ready_o == 1'b1, "R10 abort ready", in_ready_o, 1);
    quiet_window(14, "R10 abort no output");
    m_u1 = 0; m_u2 = 0;
    run_sample(-15000, "R10 after abort");

    // R10 sample offered together with clear is discarded
    @(negedge clk_i);
    while (!in_ready_o) @(negedge clk_i);
    in_valid_i = 1'b1;
    clear_i    = 1'b1;
    in_data_i  = 16'd11111;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    clear_i    = 1'b0;
    quiet_window(14, "R10 discarded with clear");
    m_u1 = 0; m_u2 = 0;
    run_sample(0, "R10 zero after clear");

    // R5 tiny alternation exposes lsb masking
    for (int i = 0; i < 60; i++) begin
      run_sample((i % 2 == 0) ? 3 : -2, "R5 small signal");
    end

    // R6 R9 full-scale steps
    for (int i = 0; i < 40; i++) run_sample(-32768, "R6 R9 low plateau");
    for (int i = 0; i < 40; i++) run_sample(32767, "R6 R9 high plateau");
    for (int i = 0; i < 20; i++) run_sample(-32768, "R6 R9 step down");

    // R6 R9 worst-case sign pattern from the model's impulse response
    su1 = m_u1; su2 = m_u2; ssat = sat_events;
    m_u1 = 0; m_u2 = 0;
    for (int i = 0; i < HLEN; i++) begin
      model_step((i == 0) ? 16384 : 0, e16, e32);
      hresp[i] = e32;
    end
    m_u1 = su1; m_u2 = su2; sat_events = ssat;
    for (int i = 0; i < HLEN; i++) begin
      run_sample((hresp[HLEN-1-i] >= 0) ? 32767 : -32768, "R6 R9 sign pattern");
    end
    for (int i = 0; i < HLEN; i++) begin
      run_sample((hresp[HLEN-1-i] >= 0) ? -32768 : 32767, "R6 R9 inverted pattern");
    end
    $display("info: model saturation events %0d", sat_events);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule